// File: doc/BRIEF.md
# Strobe-Driven Slave FIFO Port

This block lets an external master fill and drain four byte-wide endpoint FIFOs through plain level strobes that have no relation to the local clock. Chip select, the write strobe, the read strobe and the packet-end strobe each pass through a two-flop synchroniser. Edge detectors in the local clock domain then turn them into single-cycle actions. The master selects an endpoint with a 2-bit address. The full and empty flags always describe the endpoint that is currently addressed.

A write stores the byte that was on the data input while the write strobe was still active. The store happens at the trailing edge of that strobe. A read moves the head byte of the addressed FIFO into the output register at the leading edge of the read strobe, so until then the bus keeps the byte from the previous read. Each endpoint counts the bytes written into its open packet. A packet-end pulse closes that packet, even when it is short or empty. The closure appears as a record with the endpoint number and the byte count on a valid/ready stream. The record is held there until the consumer accepts it.

Top module: `strobe_fifo_port`

## Requirements
- R1: A write or read strobe acts only while chip select is also high. With chip select low, a write strobe leaves the addressed FIFO unchanged, so its empty flag stays 1.
- R2: A write stores the data-input value present at the last local sample before the write strobe (ANDed with chip select) goes low. A value that changes while the strobe is held replaces the earlier one.
- R3: Bytes written to one endpoint are read back from that endpoint in the order written, independently of traffic to other endpoints.
- R4: A read fetches the head byte at the leading edge of the read strobe. Until that fetch takes effect, dataOut keeps the previously fetched byte.
- R5: dataDrive is 1 exactly while oe is 1.
- R6: A rising edge of pktEnd presents pktValid=1, pktEp equal to the addressed endpoint, and pktLen equal to the number of bytes written to that endpoint since its last commit. The open count then restarts at 0.
- R7: pktEnd with no bytes written since the last commit presents a record with pktLen=0.
- R8: A rising edge of pktEnd while the write strobe is active sets the sticky protoErr bit and presents no record.
- R9: full is 1 when the addressed FIFO holds DEPTH bytes (default 16) and empty is 1 when it holds none. The flags follow a write within a fixed few cycles of the trailing edge.
- R10: A write to a full FIFO is dropped and sets the sticky wrErr bit. A read from an empty FIFO is dropped, leaves dataOut unchanged and sets the sticky rdErr bit.
- R11: A record with pktReady low stays valid with unchanged pktEp and pktLen. A pktEnd arriving while a record waits sets protoErr and does not replace the waiting record.
- R12: After reset, empty=1, full=0, pktValid=0, all error bits are 0 and dataOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoAddr | input | 2 | Endpoint select |
| cs | input | 1 | Chip select, active high |
| wrStb | input | 1 | Write strobe, active high |
| rdStb | input | 1 | Read strobe, active high |
| oe | input | 1 | Output enable for the data bus |
| pktEnd | input | 1 | Commit the open packet of the addressed endpoint |
| dataIn | input | DATA_W | Write data from the master |
| dataOut | output | DATA_W | Last fetched byte |
| dataDrive | output | 1 | Bus driver enable for dataOut |
| full | output | 1 | Addressed FIFO is full |
| empty | output | 1 | Addressed FIFO is empty |
| pktValid | output | 1 | Commit record is valid |
| pktReady | input | 1 | Consumer accepts the commit record |
| pktEp | output | 2 | Endpoint of the committed packet |
| pktLen | output | CNT_W | Byte count of the committed packet |
| wrErr | output | 1 | Sticky: write to a full FIFO |
| rdErr | output | 1 | Sticky: read from an empty FIFO |
| protoErr | output | 1 | Sticky: commit during a write or while a record waits |

## Verification
The assertions assume that every strobe level and every gap between strobes lasts at least three local clock cycles. They also assume that fifoAddr and dataIn stay steady for that long around each trailing write edge. The stimulus tasks hold every strobe for four cycles and wait at least four more afterwards. They change address and data only on the falling clock edge, and they move dataIn in the middle of a held strobe only where that is the point of a test. The consumer side drives pktReady low except for single-cycle accept pulses, so that records can be observed while they are held.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int ADDR_W   = 2;
  localparam int NUM_FIFO = 1 << ADDR_W;

  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic              commit;
    logic [ADDR_W-1:0] wrSel;
    logic [ADDR_W-1:0] rdSel;
  } sfpCmd_t;
endpackage

// File: rtl/sfp_ctrl.sv
module sfp_ctrl
  import sfp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   fifoAddr,
  input  logic                cs,
  input  logic                wrStb,
  input  logic                rdStb,
  input  logic                pktEnd,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [NUM_FIFO-1:0] fullVec,
  input  logic [NUM_FIFO-1:0] emptyVec,
  input  logic                pktValid,
  input  logic                pktReady,
  output sfpCmd_t             cmd,
  output logic [DATA_W-1:0]   wrData,
  output logic                wrErr,
  output logic                rdErr,
  output logic                protoErr
);
  localparam int BUS_W = ADDR_W + DATA_W;

  // strobe synchroniser: bit0 cs, bit1 wr, bit2 rd, bit3 pktEnd
  logic [3:0]       syncA, syncB;
  logic [BUS_W-1:0] busA, busB, busC;
  logic             prevWr, prevRd, prevPk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= '0;
      syncB  <= '0;
      busA   <= '0;
      busB   <= '0;
      busC   <= '0;
      prevWr <= 1'b0;
      prevRd <= 1'b0;
      prevPk <= 1'b0;
    end else begin
      syncA  <= {pktEnd, rdStb, wrStb, cs};
      syncB  <= syncA;
      busA   <= {fifoAddr, dataIn};
      busB   <= busA;
      busC   <= busB;
      prevWr <= wrAct;
      prevRd <= rdAct;
      prevPk <= pkAct;
    end
  end

  logic wrAct, rdAct, pkAct;
  logic wrFall, rdRise, pkRise, pkBad;
  logic [ADDR_W-1:0] addrNow, addrOld;

  assign wrAct   = syncB[0] & syncB[1];
  assign rdAct   = syncB[0] & syncB[2];
  assign pkAct   = syncB[3];
  assign wrFall  = prevWr & ~wrAct;
  assign rdRise  = rdAct & ~prevRd;
  assign pkRise  = pkAct & ~prevPk;
  assign addrNow = busB[BUS_W-1:DATA_W];
  assign addrOld = busC[BUS_W-1:DATA_W];
  assign wrData  = busC[DATA_W-1:0];
  assign pkBad   = pkRise & (wrAct | (pktValid & ~pktReady));

  always_comb begin
    cmd        = '0;
    cmd.wrSel  = addrOld;
    cmd.rdSel  = addrNow;
    cmd.wrEn   = wrFall & ~fullVec[addrOld];
    cmd.rdEn   = rdRise & ~emptyVec[addrNow];
    cmd.commit = pkRise & ~pkBad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrErr    <= 1'b0;
      rdErr    <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      if (wrFall && fullVec[addrOld]) wrErr <= 1'b1;
      if (rdRise && emptyVec[addrNow]) rdErr <= 1'b1;
      if (pkBad) protoErr <= 1'b1;
    end
  end
endmodule

// File: rtl/sfp_data.sv
module sfp_data
  import sfp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  sfpCmd_t             cmd,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                pktReady,
  output logic [NUM_FIFO-1:0] fullVec,
  output logic [NUM_FIFO-1:0] emptyVec,
  output logic [DATA_W-1:0]   dataOut,
  output logic                full,
  output logic                empty,
  output logic                pktValid,
  output logic [ADDR_W-1:0]   pktEp,
  output logic [CNT_W-1:0]    pktLen
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] headArr [NUM_FIFO];
  logic [CNT_W-1:0]  openArr [NUM_FIFO];

  for (genvar i = 0; i < NUM_FIFO; i++) begin : g_fifo
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wrPtr, rdPtr;
    logic [CNT_W-1:0]  fillCnt, openCnt;
    logic              we, re, mine;

    assign we   = cmd.wrEn && (cmd.wrSel == ADDR_W'(i));
    assign re   = cmd.rdEn && (cmd.rdSel == ADDR_W'(i));
    assign mine = cmd.commit && (cmd.rdSel == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (we) mem[wrPtr] <= wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrPtr   <= '0;
        rdPtr   <= '0;
        fillCnt <= '0;
        openCnt <= '0;
      end else begin
        if (we) wrPtr <= (wrPtr == PTR_MAX) ? '0 : wrPtr + 1'b1;
        if (re) rdPtr <= (rdPtr == PTR_MAX) ? '0 : rdPtr + 1'b1;
        if (we && !re)      fillCnt <= fillCnt + 1'b1;
        else if (re && !we) fillCnt <= fillCnt - 1'b1;
        if (mine)                         openCnt <= we ? CNT_W'(1) : '0;
        else if (we && openCnt != CNT_MAX) openCnt <= openCnt + 1'b1;
      end
    end

    assign fullVec[i]  = (fillCnt == CNT_MAX);
    assign emptyVec[i] = (fillCnt == '0);
    assign headArr[i]  = mem[rdPtr];
    assign openArr[i]  = openCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut  <= '0;
      full     <= 1'b0;
      empty    <= 1'b1;
      pktValid <= 1'b0;
      pktEp    <= '0;
      pktLen   <= '0;
    end else begin
      if (cmd.rdEn) dataOut <= headArr[cmd.rdSel];
      full  <= fullVec[cmd.rdSel];
      empty <= emptyVec[cmd.rdSel];
      if (cmd.commit) begin
        pktValid <= 1'b1;
        pktEp    <= cmd.rdSel;
        pktLen   <= openArr[cmd.rdSel];
      end else if (pktReady) begin
        pktValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/strobe_fifo_port.sv
module strobe_fifo_port
  import sfp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        fifoAddr,
  input  logic              cs,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic              oe,
  input  logic              pktEnd,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataDrive,
  output logic              full,
  output logic              empty,
  output logic              pktValid,
  input  logic              pktReady,
  output logic [1:0]        pktEp,
  output logic [CNT_W-1:0]  pktLen,
  output logic              wrErr,
  output logic              rdErr,
  output logic              protoErr
);
  sfpCmd_t             cmd;
  logic [DATA_W-1:0]   wrData;
  logic [NUM_FIFO-1:0] fullVec, emptyVec;

  sfp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoAddr(fifoAddr), .cs(cs), .wrStb(wrStb),
    .rdStb(rdStb), .pktEnd(pktEnd), .dataIn(dataIn), .fullVec(fullVec),
    .emptyVec(emptyVec), .pktValid(pktValid), .pktReady(pktReady),
    .cmd(cmd), .wrData(wrData), .wrErr(wrErr), .rdErr(rdErr),
    .protoErr(protoErr)
  );

  sfp_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(wrData),
    .pktReady(pktReady), .fullVec(fullVec), .emptyVec(emptyVec),
    .dataOut(dataOut), .full(full), .empty(empty), .pktValid(pktValid),
    .pktEp(pktEp), .pktLen(pktLen)
  );

  assign dataDrive = oe;
endmodule

// File: rtl/sfp_checker.sv
module sfp_checker #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             full,
  input logic             empty,
  input logic             pktValid,
  input logic             pktReady,
  input logic [1:0]       pktEp,
  input logic [CNT_W-1:0] pktLen,
  input logic             wrErr,
  input logic             rdErr,
  input logic             protoErr
);
  a_r10_wrerr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |=> wrErr);
  a_r10_rderr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |=> rdErr);
  a_r8_proto_sticky: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);
  a_r11_record_held: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktReady) |=> (pktValid && $stable(pktLen) && $stable(pktEp)));
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));
  a_r6_len_bound: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> (pktLen <= CNT_W'(DEPTH)));
endmodule

bind strobe_fifo_port sfp_checker u_chk (
  .clk(clk), .rstN(rstN), .full(full), .empty(empty), .pktValid(pktValid),
  .pktReady(pktReady), .pktEp(pktEp), .pktLen(pktLen), .wrErr(wrErr),
  .rdErr(rdErr), .protoErr(protoErr)
);

// File: tb/test_strobe_fifo_port.sv
module test_strobe_fifo_port;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] fifoAddr = '0;
  logic cs = 0, wrStb = 0, rdStb = 0, oe = 0, pktEnd = 0, pktReady = 0;
  logic [7:0] dataIn = '0, dataOut;
  logic dataDrive, full, empty, pktValid, wrErr, rdErr, protoErr;
  logic [1:0] pktEp;
  logic [CNT_W-1:0] pktLen;

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  strobe_fifo_port #(.DATA_W(8), .DEPTH(DEPTH)) i_strobe_fifo_port (
    .clk(clk), .rstN(rstN), .fifoAddr(fifoAddr), .cs(cs), .wrStb(wrStb),
    .rdStb(rdStb), .oe(oe), .pktEnd(pktEnd), .dataIn(dataIn),
    .dataOut(dataOut), .dataDrive(dataDrive), .full(full), .empty(empty),
    .pktValid(pktValid), .pktReady(pktReady), .pktEp(pktEp), .pktLen(pktLen),
    .wrErr(wrErr), .rdErr(rdErr), .protoErr(protoErr)
  );

  // op: 0 write, 1 read (exp = byte), 2 packet end (exp = length)
  typedef struct packed { logic [1:0] op; logic [1:0] addr; logic [7:0] data; logic [7:0] exp; } vec_t;
  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd0, 8'hA1, 8'h00}, '{2'd0, 2'd0, 8'hB2, 8'h00},
    '{2'd0, 2'd0, 8'hC3, 8'h00}, '{2'd0, 2'd0, 8'hD4, 8'h00},
    '{2'd2, 2'd0, 8'h00, 8'd4},  '{2'd0, 2'd1, 8'h55, 8'h00},
    '{2'd2, 2'd1, 8'h00, 8'd1},  '{2'd2, 2'd2, 8'h00, 8'd0},
    '{2'd1, 2'd0, 8'h00, 8'hA1}, '{2'd1, 2'd0, 8'h00, 8'hB2},
    '{2'd0, 2'd3, 8'h77, 8'h00}, '{2'd1, 2'd3, 8'h00, 8'h77},
    '{2'd1, 2'd0, 8'h00, 8'hC3}, '{2'd1, 2'd0, 8'h00, 8'hD4}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [7:0] d);
    fifoAddr = a; dataIn = d; cs = 1; wrStb = 1;
    cyc(4);
    wrStb = 0; cs = 0;
    cyc(5);
  endtask

  task automatic doRead(input logic [1:0] a);
    fifoAddr = a; cs = 1; rdStb = 1;
    cyc(4);
    rdStb = 0; cs = 0;
    cyc(4);
  endtask

  task automatic doPkt(input logic [1:0] a);
    fifoAddr = a; pktEnd = 1;
    cyc(4);
    pktEnd = 0;
    cyc(4);
  endtask

  task automatic popRecord();
    pktReady = 1; cyc(1); pktReady = 0; cyc(1);
  endtask

  task automatic doReset();
    rstN = 0; cyc(3); rstN = 1; cyc(2);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(2);
    // R12 reset state
    check("R12 empty", empty, 1); check("R12 full", full, 0);
    check("R12 pktValid", pktValid, 0); check("R12 dataOut", dataOut, 0);
    check("R12 errs", {wrErr, rdErr, protoErr}, 0);
    doReset();

    // R1: write strobe without chip select is ignored
    fifoAddr = 2; dataIn = 8'h3C; wrStb = 1; cyc(4); wrStb = 0; cyc(5);
    check("R1 empty after cs-low write", empty, 1);

    oe = 1;
    for (int i = 0; i < NVEC; i++) begin
      case (VECS[i].op)
        2'd0: doWrite(VECS[i].addr, VECS[i].data);
        2'd1: begin
          doRead(VECS[i].addr);
          check("R3 read order", dataOut, VECS[i].exp);
        end
        default: begin
          doPkt(VECS[i].addr);
          check("R6 pktValid", pktValid, 1);
          check("R6 pktEp", pktEp, VECS[i].addr);
          check(VECS[i].exp == 0 ? "R7 zero length" : "R6 pktLen", pktLen, VECS[i].exp);
          popRecord();
          check("R6 record accepted", pktValid, 0);
        end
      endcase
    end

    // R4: bus holds previous byte until the fetch
    doWrite(2'd1, 8'h99);
    fifoAddr = 1; cs = 1; rdStb = 1; cyc(1);
    check("R4 previous byte held", dataOut, 8'hD4);
    cyc(3); rdStb = 0; cs = 0; cyc(4);
    check("R4 fetched byte", dataOut, 8'h55);

    // R5: output enable
    oe = 0; #1;
    check("R5 drive off", dataDrive, 0);
    oe = 1; #1;
    check("R5 drive on", dataDrive, 1);

    // R2: trailing-edge capture
    fifoAddr = 2; dataIn = 8'h11; cs = 1; wrStb = 1; cyc(2);
    dataIn = 8'h22; cyc(2); wrStb = 0; cs = 0; cyc(5);
    doRead(2'd2);
    check("R2 late data stored", dataOut, 8'h22);

    // R11: held record, second commit rejected
    doPkt(2'd0);
    cyc(6);
    check("R11 held valid", pktValid, 1);
    doPkt(2'd1);
    check("R11 protoErr", protoErr, 1);
    check("R11 record unchanged", {pktEp, pktLen}, {2'd0, CNT_W'(0)});
    popRecord();

    // R8: packet end during a write
    doReset();
    fifoAddr = 3; dataIn = 8'h42; cs = 1; wrStb = 1; cyc(4);
    pktEnd = 1; cyc(4); pktEnd = 0; cyc(2);
    check("R8 protoErr", protoErr, 1);
    check("R8 no record", pktValid, 0);
    wrStb = 0; cs = 0; cyc(5);

    // R9 / R10: fill, overflow, drain, underflow
    doReset();
    for (int i = 0; i < DEPTH; i++) begin
      doWrite(2'd0, 8'(i + 8'h10));
      if (i == 0) check("R9 not empty", empty, 0);
    end
    check("R9 full", full, 1);
    doWrite(2'd0, 8'hEE);
    check("R10 wrErr", wrErr, 1);
    for (int i = 0; i < DEPTH; i++) begin
      doRead(2'd0);
      check("R10 dropped overflow byte", dataOut, 8'(i + 8'h10));
    end
    check("R9 empty", empty, 1);
    check("R9 not full", full, 0);
    doRead(2'd0);
    check("R10 rdErr", rdErr, 1);
    check("R10 dataOut unchanged", dataOut, 8'h1F);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule